// File: doc/BRIEF.md
# Two-Way Data Cache with Per-Access Write Policy

This block is a two-way set-associative data cache of 4 KB (128 sets of 16-byte lines) that sits between a CPU load/store port and a memory port. Every CPU access carries a 2-bit policy taken from the page it belongs to. That policy decides, access by access, whether the arrays are used at all, and whether a store also goes to memory (write-through) or stays in the line until eviction (copy-back).

The CPU holds `cpuReq` and its fields steady until `cpuReady` is high for one cycle. Hits complete in the cycle they are presented. Misses, uncached accesses and write-through stores wait for one memory transaction at a time. Each transaction on the memory side is held until the responder returns a one-cycle `memAck`.

Top module: `dcache_pagepol`

## Requirements
- R1: After reset, `memReq` and `cpuReady` are low while no request is pending, and every line is invalid, so the first cacheable read of a line causes a line fill (`memOp` = 2'b01) and no writeback.
- R2: A cacheable read that hits returns the word with `cpuReady` high in the cycle the request is presented, and starts no memory transaction.
- R3: A copy-back store (policy 2'b10) that hits updates only the cached line under the byte enables and marks it dirty. It completes in the same cycle and starts no memory transaction.
- R4: A write-through store (policy 2'b01) produces exactly one word write (`memOp` = 2'b10) carrying the byte enables, so memory holds the merged word afterwards. A store that misses does not allocate, and a later read of that line fills it.
- R5: Policies 2'b00 and 2'b11 are uncached. A read issues one word read (`memOp` = 2'b00) returned in `memRdata[31:0]` and never allocates, so a repeat read goes to memory again. A store issues one word write.
- R6: A copy-back store that misses first fills the line, then merges the store into it, and issues no word write.
- R7: On a miss the victim line, if dirty, is written back whole (`memOp` = 2'b11 at the victim's own line address) before the fill is requested. A clean or invalid victim is not written back.
- R8: Replacement takes an invalid way first and otherwise the least recently used way of the set, where both hits and fills count as use. Addresses 2 KB apart share a set (index = address bits [10:4]).
- R9: At most one memory transaction is outstanding. `memReq`, `memOp` and `memAddr` stay steady from request until `memAck`.
- R10: With a fixed policy per page, every read returns the latest data the CPU stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Access request, held until cpuReady |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuBe | input | 4 | Byte enables for a store |
| cpuWdata | input | 32 | Store data |
| cpuPolicy | input | 2 | 00 uncached, 01 write-through, 10 copy-back, 11 uncached |
| cpuReady | output | 1 | Access complete this cycle |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| memReq | output | 1 | Memory transaction request |
| memOp | output | 2 | 00 word read, 01 line read, 10 word write, 11 line write |
| memAddr | output | ADDR_W | Transaction address (line-aligned for line ops) |
| memBe | output | 4 | Byte enables for a word write |
| memWdata | output | LINE_W | Line data, or the word in bits [31:0] |
| memAck | input | 1 | One-cycle completion of the transaction |
| memRdata | input | LINE_W | Fill line (word 0 in the low bits) or the word in bits [31:0] |

## Verification
If a dirty bit is lost, an evicted copy-back line shows up as a stale word on the next miss to its address. That surfaces within one fill of the conflicting access. A wrong LRU bit or a spurious allocation changes the count and kind of memory operations seen during an access that should have hit, so the error shows at the port on that same access. A corrupted merge or a wrong word select shows up on the next load of that address as a mismatch against the bench's shadow copy.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W = WORD_BYTES * 8;

  typedef enum logic [1:0] {
    MEM_RD_WORD = 2'b00,
    MEM_RD_LINE = 2'b01,
    MEM_WR_WORD = 2'b10,
    MEM_WR_LINE = 2'b11
  } memOp_e;

  localparam logic [1:0] POL_WT = 2'b01;
  localparam logic [1:0] POL_CB = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic wrWord;
    logic setDirty;
    logic touch;
    logic fill;
  } dpStrobe_t;

  function automatic logic isCached(input logic [1:0] pol);
    return (pol == POL_WT) || (pol == POL_CB);
  endfunction
endpackage

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS = 128,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WSEL_W = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [3:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        cpuPolicy,
  input  dpStrobe_t         strobe,
  input  logic [LINE_W-1:0] memLine,
  output logic              hit,
  output logic [WORD_W-1:0] rdWord,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [LINE_W-1:0] victimLine
);
  localparam int NWAYS = 2;

  logic [TAG_W-1:0]  tagArr  [NWAYS][SETS];
  logic [LINE_W-1:0] dataArr [NWAYS][SETS];
  logic [SETS-1:0]   validBits [NWAYS];
  logic [SETS-1:0]   dirtyBits [NWAYS];
  logic [SETS-1:0]   lruBits;

  logic [NWAYS-1:0] wayHit;
  logic             hitWay, victimWay;
  logic [LINE_W-1:0] hitLine, mergeLine;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign wayHit[w] = validBits[w][idx] && (tagArr[w][idx] == tag);
  end

  assign hit       = |wayHit;
  assign hitWay    = wayHit[1];
  assign victimWay = !validBits[0][idx] ? 1'b0 :
                     !validBits[1][idx] ? 1'b1 : lruBits[idx];
  assign hitLine   = dataArr[hitWay][idx];
  assign rdWord    = hitLine[int'(wsel)*WORD_W +: WORD_W];

  assign victimDirty = validBits[victimWay][idx] && dirtyBits[victimWay][idx];
  assign victimAddr  = {tagArr[victimWay][idx], idx, {OFF_W{1'b0}}};
  assign victimLine  = dataArr[victimWay][idx];

  always_comb begin
    mergeLine = hitLine;
    for (int b = 0; b < WORD_BYTES; b++)
      if (be[b]) mergeLine[int'(wsel)*WORD_W + b*8 +: 8] = wdata[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NWAYS; w++) begin
        validBits[w] <= '0;
        dirtyBits[w] <= '0;
      end
      lruBits <= '0;
    end else begin
      for (int w = 0; w < NWAYS; w++) begin
        if (strobe.fill && victimWay == 1'(w)) begin
          validBits[w][idx] <= 1'b1;
          dirtyBits[w][idx] <= 1'b0;
        end else if (strobe.wrWord && strobe.setDirty && hitWay == 1'(w)) begin
          dirtyBits[w][idx] <= 1'b1;
        end
      end
      if (strobe.fill)       lruBits[idx] <= ~victimWay;
      else if (strobe.touch) lruBits[idx] <= ~hitWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagArr[victimWay][idx]  <= tag;
      dataArr[victimWay][idx] <= memLine;
    end else if (strobe.wrWord) begin
      dataArr[hitWay][idx] <= mergeLine;
    end
  end

  // R1
  fillOnMiss_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |-> !hit);
  // R3
  dirtyOnlyCb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDirty |-> (cpuPolicy == POL_CB) && hit);
  // R5
  fillCached_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |-> isCached(cpuPolicy));
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [1:0]        cpuPolicy,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [ADDR_W-1:0] lineAddr,
  input  logic              hit,
  input  logic              victimDirty,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              memAck,
  output logic              cpuReady,
  output logic              fromMem,
  output dpStrobe_t         strobe,
  output logic              memReq,
  output memOp_e            memOp,
  output logic [ADDR_W-1:0] memAddr
);
  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_WWORD, S_RWORD} state_e;
  state_e state, nextState;
  logic   cached, isCb, wbDone;

  assign cached = isCached(cpuPolicy);
  assign isCb   = (cpuPolicy == POL_CB);

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    fromMem   = 1'b0;
    memReq    = 1'b0;
    memOp     = MEM_RD_WORD;
    memAddr   = wordAddr;
    unique case (state)
      S_IDLE: if (cpuReq) begin
        if (!cached) begin
          nextState = cpuWe ? S_WWORD : S_RWORD;
        end else if (hit) begin
          strobe.touch = 1'b1;
          if (cpuWe) begin
            strobe.wrWord   = 1'b1;
            strobe.setDirty = isCb;
            if (isCb) cpuReady = 1'b1;
            else      nextState = S_WWORD;
          end else begin
            cpuReady = 1'b1;
          end
        end else if (cpuWe && !isCb) begin
          nextState = S_WWORD;
        end else begin
          nextState = victimDirty ? S_WB : S_FILL;
        end
      end
      S_WB: begin
        memReq  = 1'b1;
        memOp   = MEM_WR_LINE;
        memAddr = victimAddr;
        if (memAck) nextState = S_FILL;
      end
      S_FILL: begin
        memReq  = 1'b1;
        memOp   = MEM_RD_LINE;
        memAddr = lineAddr;
        if (memAck) begin
          strobe.fill = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_WWORD: begin
        memReq = 1'b1;
        memOp  = MEM_WR_WORD;
        if (memAck) begin
          cpuReady  = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_RWORD: begin
        memReq = 1'b1;
        memOp  = MEM_RD_WORD;
        if (memAck) begin
          cpuReady  = 1'b1;
          fromMem   = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      wbDone <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_WB && memAck) wbDone <= 1'b1;
      else if (state == S_IDLE)    wbDone <= 1'b0;
    end
  end

  // R9
  memHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memOp));
  // R7
  wbBeforeFill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL) && memAck |-> !victimDirty || wbDone);
  // R10
  readyWithReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);
  // R1
  idleQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq && (state == S_IDLE) |-> !memReq && !cpuReady);
endmodule

// File: rtl/dcache_pagepol.sv
module dcache_pagepol
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS = 128,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [3:0]        cpuBe,
  input  logic [31:0]       cpuWdata,
  input  logic [1:0]        cpuPolicy,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [LINE_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [LINE_W-1:0] memRdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WB_W   = $clog2(WORD_BYTES);
  localparam int WSEL_W = $clog2(LINE_BYTES / WORD_BYTES);

  dpStrobe_t         strobe;
  logic              hit, victimDirty, fromMem;
  logic [WORD_W-1:0] rdWord;
  logic [ADDR_W-1:0] victimAddr, lineAddr;
  logic [LINE_W-1:0] victimLine;
  memOp_e            op;

  assign lineAddr = {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  dcache_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .cpuReq, .cpuWe, .cpuPolicy,
    .wordAddr(cpuAddr), .lineAddr,
    .hit, .victimDirty, .victimAddr, .memAck,
    .cpuReady, .fromMem, .strobe,
    .memReq, .memOp(op), .memAddr
  );

  dcache_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)) u_dp (
    .clk, .rstN,
    .idx(cpuAddr[OFF_W +: IDX_W]),
    .tag(cpuAddr[ADDR_W-1 -: TAG_W]),
    .wsel(cpuAddr[WB_W +: WSEL_W]),
    .be(cpuBe), .wdata(cpuWdata), .cpuPolicy, .strobe,
    .memLine(memRdata),
    .hit, .rdWord, .victimDirty, .victimAddr, .victimLine
  );

  assign memOp    = op;
  assign memBe    = cpuBe;
  assign memWdata = (op == MEM_WR_LINE) ? victimLine
                                        : {{(LINE_W-WORD_W){1'b0}}, cpuWdata};
  assign cpuRdata = fromMem ? memRdata[WORD_W-1:0] : rdWord;
endmodule

// File: tb/dcache_pagepol_test.sv
`timescale 1ns/1ps
module dcache_pagepol_test;
  logic         clk = 0, rstN = 0;
  logic         cpuReq = 0, cpuWe = 0, cpuReady, memReq, memAck = 0;
  logic [31:0]  cpuAddr = 0, cpuWdata = 0, cpuRdata, memAddr;
  logic [3:0]   cpuBe = 0, memBe;
  logic [1:0]   cpuPolicy = 0, memOp;
  logic [127:0] memWdata, memRdata = '0;

  dcache_pagepol uut (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0, waits;
  int opCnt [4];
  int firstOp;
  bit anyOp;
  logic [31:0] mem [4096];
  logic [31:0] shadow [4096];

  function automatic logic [31:0] initVal(input int i);
    return i * 32'h9E3779B1 + 32'h1357;
  endfunction

  function automatic logic [31:0] mergeBe(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // memory responder: one transaction at a time, 0..2 cycles latency
  initial begin
    forever begin
      @(negedge clk);
      memAck = 0;
      if (memReq) begin
        automatic int lat = $urandom_range(0, 2);
        automatic logic [31:0] a0 = memAddr;
        automatic logic [1:0] o0 = memOp;
        automatic int wi = int'(a0[13:2]);
        automatic int li = int'({a0[13:4], 2'b00});
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          // R9: request held steady until acknowledged
          chk(memReq && memAddr == a0 && memOp == o0, "R9", memAddr, a0);
        end
        case (o0)
          2'b00: memRdata = {96'b0, mem[wi]};
          2'b01: memRdata = {mem[li+3], mem[li+2], mem[li+1], mem[li]};
          2'b10: mem[wi] = mergeBe(mem[wi], memWdata[31:0], memBe);
          default: for (int j = 0; j < 4; j++) mem[li+j] = memWdata[j*32 +: 32];
        endcase
        opCnt[o0]++;
        if (!anyOp) firstOp = int'(o0);
        anyOp = 1;
        memAck = 1;
      end
    end
  end

  task automatic acc(input logic [31:0] a, input bit we, input logic [3:0] be,
                     input logic [31:0] wd, input logic [1:0] pol, output logic [31:0] rd);
    @(negedge clk);
    for (int j = 0; j < 4; j++) opCnt[j] = 0;
    anyOp = 0; firstOp = -1; waits = 0;
    cpuReq = 1; cpuAddr = a; cpuWe = we; cpuBe = be; cpuWdata = wd; cpuPolicy = pol;
    forever begin
      #2;
      if (cpuReady) break;
      waits++;
      if (waits > 100) begin
        chk(0, "R10 access hung", 0, 1);
        break;
      end
      @(negedge clk);
    end
    rd = cpuRdata;
    @(posedge clk);
    #1 cpuReq = 0;
    if (we) shadow[a[13:2]] = mergeBe(shadow[a[13:2]], wd, be);
  endtask

  function automatic logic [1:0] pagePol(input logic [31:0] a);
    case (a[13:12])
      2'd0: return ($urandom_range(0, 1) != 0) ? 2'b11 : 2'b00;
      2'd1: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd, v;
    logic [31:0] A = 32'h2050, B = 32'h2850, C = 32'h3050, D = 32'h3850;
    logic [31:0] E = 32'h2068, F = 32'h1044, G = 32'h1080, H = 32'h0104;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin mem[i] = initVal(i); shadow[i] = initVal(i); end
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk(!memReq && !cpuReady, "R1 idle after reset", {memReq, cpuReady}, 0);

    acc(A, 0, 0, 0, 2'b10, rd);
    chk(rd == shadow[A[13:2]], "R10 read A", rd, shadow[A[13:2]]);
    chk(opCnt[1] == 1 && opCnt[3] == 0, "R1 first read fills", opCnt[1], 1);
    acc(A, 0, 0, 0, 2'b10, rd);
    chk(waits == 0 && !anyOp, "R2 hit latency", waits, 0);
    acc(A, 1, 4'b0011, 32'hCAFE_BEEF, 2'b10, rd);
    chk(waits == 0 && !anyOp, "R3 cb hit quiet", waits, 0);
    chk(mem[A[13:2]] == initVal(int'(A[13:2])), "R3 memory untouched", mem[A[13:2]], initVal(int'(A[13:2])));
    acc(B, 0, 0, 0, 2'b10, rd);
    chk(opCnt[3] == 0 && opCnt[1] == 1, "R8 invalid way first", opCnt[3], 0);
    acc(A, 0, 0, 0, 2'b10, rd);
    chk(!anyOp && rd == shadow[A[13:2]], "R2 merged hit data", rd, shadow[A[13:2]]);
    acc(C, 0, 0, 0, 2'b10, rd);
    chk(opCnt[3] == 0, "R7 clean victim not written", opCnt[3], 0);
    acc(A, 0, 0, 0, 2'b10, rd);
    chk(!anyOp, "R8 LRU kept A", opCnt[1], 0);
    acc(C, 0, 0, 0, 2'b10, rd);
    acc(D, 0, 0, 0, 2'b10, rd);
    chk(opCnt[3] == 1 && firstOp == 3 && opCnt[1] == 1, "R7 dirty writeback first", firstOp, 3);
    chk(mem[A[13:2]] == shadow[A[13:2]], "R7 written back data", mem[A[13:2]], shadow[A[13:2]]);
    acc(A, 0, 0, 0, 2'b10, rd);
    chk(rd == shadow[A[13:2]], "R10 refetch A", rd, shadow[A[13:2]]);

    acc(E, 1, 4'b1001, 32'h1122_3344, 2'b10, rd);
    chk(opCnt[1] == 1 && opCnt[2] == 0, "R6 cb miss fills", opCnt[2], 0);
    acc(E, 0, 0, 0, 2'b10, rd);
    chk(!anyOp && rd == shadow[E[13:2]], "R6 merged after fill", rd, shadow[E[13:2]]);

    acc(F, 0, 0, 0, 2'b01, rd);
    acc(F, 1, 4'b1111, 32'h0BAD_F00D, 2'b01, rd);
    chk(opCnt[2] == 1 && mem[F[13:2]] == 32'h0BAD_F00D, "R4 wt hit to memory", mem[F[13:2]], 32'h0BAD_F00D);
    acc(F, 0, 0, 0, 2'b01, rd);
    chk(!anyOp && rd == 32'h0BAD_F00D, "R4 wt hit cache updated", rd, 32'h0BAD_F00D);
    acc(G, 1, 4'b0100, 32'h00AB_0000, 2'b01, rd);
    chk(opCnt[2] == 1 && opCnt[1] == 0, "R4 wt miss no fill", opCnt[1], 0);
    chk(mem[G[13:2]] == shadow[G[13:2]], "R4 wt miss memory", mem[G[13:2]], shadow[G[13:2]]);
    acc(G, 0, 0, 0, 2'b01, rd);
    chk(opCnt[1] == 1 && rd == shadow[G[13:2]], "R4 not allocated", opCnt[1], 1);

    acc(H, 0, 0, 0, 2'b00, rd);
    chk(opCnt[0] == 1 && opCnt[1] == 0 && rd == shadow[H[13:2]], "R5 uncached read", rd, shadow[H[13:2]]);
    acc(H, 0, 0, 0, 2'b11, rd);
    chk(opCnt[0] == 1 && opCnt[1] == 0, "R5 code 11 no allocate", opCnt[0], 1);
    acc(H, 1, 4'b0010, 32'h0000_7700, 2'b11, rd);
    chk(opCnt[2] == 1 && mem[H[13:2]] == shadow[H[13:2]], "R5 uncached write", mem[H[13:2]], shadow[H[13:2]]);

    // constrained random: few sets, several tags, all pages
    for (int n = 0; n < 600; n++) begin
      automatic logic [31:0] a = ($urandom_range(0, 3) << 12) | ($urandom_range(0, 1) << 11)
                               | ($urandom_range(0, 3) << 4) | ($urandom_range(0, 3) << 2);
      automatic bit we = ($urandom_range(0, 2) == 0);
      automatic logic [3:0] be = 4'($urandom_range(1, 15));
      automatic logic [1:0] pol = pagePol(a);
      v = $urandom;
      acc(a, we, be, v, pol, rd);
      if (!we) chk(rd == shadow[a[13:2]], "R10 random read", rd, shadow[a[13:2]]);
      else if (pol != 2'b10) chk(mem[a[13:2]] == shadow[a[13:2]], "R4 random store", mem[a[13:2]], shadow[a[13:2]]);
      else chk(opCnt[2] == 0, "R3 cb store no word write", opCnt[2], 0);
    end
    finish_run();
  end
endmodule